// File: doc/BRIEF.md
# Priority Peripheral-to-Pin Crossbar

This block routes a fixed set of on-chip peripheral signals onto a 32-pin general-purpose I/O bank arranged as four 8-bit ports. Three 8-bit configuration words select which peripheral functions are active. Every active function then takes the next free pin, starting at pin 0 of port 0. Functions are visited in a fixed priority order. A peripheral that uses several wires takes a run of consecutive free pins. A pin left without a function drives its port latch value and port output enable.

An external memory interface can share the low port. When it is enabled there, the crossbar keeps its read and write strobe pins free, and in multiplexed-address mode it also keeps the address-latch pin free. While an external access is in progress, the memory interface drives every pin it owns, whatever the crossbar or the port latch would drive. During a read it turns off the drivers of its data-bus pins.

The allocation is registered. A configuration change reaches the pins one clock later.

Top module: `xbar_pin_crossbar`

## Requirements
- R1: Signals are numbered by priority, and `pin_sel` reports a pin's signal by that number: 0 UART0-TX, 1 UART0-RX, 2 SPI clock, 3 MISO, 4 MOSI, 5 SPI select, 6 SMBus data, 7 SMBus clock, 8 UART1-TX, 9 UART1-RX, 10..15 PCA outputs 0..5, 16 PCA count input, 17 comparator0, 18 comparator1, 19 timer0, 20 irq0, 21 timer1, 22 irq1, 23 timer2, 24 timer2-ext, 25 timer4, 26 timer4-ext, 27 clock-out, 28 convert-start0, 29 convert-start2. The enabled signals take the free pins in ascending order, lowest number first, starting at pin 0.
- R2: Each signal is enabled by one configuration bit:
  - `cfg0` bit0 enables UART0 (signals 0,1), bit1 enables SPI (2..5), bit2 enables SMBus (6,7), bit6 enables signal 16 and bit7 enables signal 17.
  - `cfg1` bits 0..7 enable signals 18..24 and 27, in that order.
  - `cfg2` bit0 enables signal 28, bit2 enables UART1 (8,9), bit3 enables signal 25, bit4 enables signal 26 and bit5 enables signal 29.
- R3: While `mem_low_en` is 1, pins 7 and 6 are never assigned a signal.
- R4: While `mem_low_en` and `mem_muxed` are both 1, pin 5 is also never assigned a signal.
- R5: While `spi_3wire` is 1, the SPI select signal (5) gets no pin and takes no slot.
- R6: `cfg0[5:3]` gives the number of PCA outputs routed, starting at signal 10. Values 6 and 7 both route all six.
- R7: Enabled signals beyond the last free pin are dropped, and `overflow` reads 1. Otherwise `overflow` reads 0.
- R8: An assigned pin drives `sig_out` and `sig_oe` of its signal. An unassigned pin reports `pin_sel` = 31 and drives `port_latch` and `port_oe`.
- R9: While `mem_act` is 1, every pin with its `mem_own` bit set drives `mem_drv` with its output enable at 1.
- R10: While `mem_act` and `mem_rd` are both 1, an owned pin whose `mem_data` bit is set has its output enable at 0.
- R11: A change to the configuration or to the reservation inputs shows on `pin_sel` and `overflow` after exactly one rising clock edge.
- R12: During reset and right after it, every pin reports 31 and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg0 | input | 8 | Configuration word 0 |
| cfg1 | input | 8 | Configuration word 1 |
| cfg2 | input | 8 | Configuration word 2 |
| spi_3wire | input | 1 | SPI in 3-wire mode; no select pin |
| mem_low_en | input | 1 | Memory interface placed on the low ports |
| mem_muxed | input | 1 | Memory interface uses multiplexed address and data |
| mem_act | input | 1 | External access in its execution phase |
| mem_rd | input | 1 | Current external access is a read |
| mem_own | input | 32 | Pins the memory interface drives during an access |
| mem_drv | input | 32 | Values the memory interface drives |
| mem_data | input | 32 | Pins that form the memory data bus |
| sig_out | input | 30 | Peripheral output value per signal |
| sig_oe | input | 30 | Peripheral output enable per signal |
| port_latch | input | 32 | Port latch data per pin |
| port_oe | input | 32 | Port output enable per pin |
| pin_sel | output | 160 | 5-bit signal number per pin, pin p at bits 5p+4:5p; 31 = unassigned |
| pin_out | output | 32 | Pin output value |
| pin_oe | output | 32 | Pin output enable |
| overflow | output | 1 | Enabled signals exceeded the free pins |

## Verification
A wrong enable decode or a wrong rank count moves every later signal by one or more pins. A single directed configuration therefore shows it on `pin_sel` one edge after the configuration is applied. A wrong reservation shows as a signal number on pins 5 to 7, and as a one-pin shift of the signals that follow. An override or read-disable fault shows on `pin_out` or `pin_oe` in the same cycle as `mem_act`, because that path has no register.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
   localparam int NSIG  = 30;
   localparam int SEL_W = 5;
   localparam int NCEX  = 6;

   typedef enum logic [SEL_W-1:0] {
      S_TX0 = 5'd0, S_RX0 = 5'd1, S_SCK = 5'd2, S_MISO = 5'd3, S_MOSI = 5'd4,
      S_SSEL = 5'd5, S_SDA = 5'd6, S_SCL = 5'd7, S_TX1 = 5'd8, S_RX1 = 5'd9,
      S_PCA0 = 5'd10, S_PCNT = 5'd16, S_CMP0 = 5'd17, S_CMP1 = 5'd18,
      S_TMR4 = 5'd25, S_TMR4X = 5'd26, S_CLKO = 5'd27, S_CNV0 = 5'd28,
      S_CNV2 = 5'd29, S_NONE = 5'd31
   } sig_id_e;
endpackage

// File: rtl/xbar_enable_decode.sv
module xbar_enable_decode
   import xbar_pkg::*;
(
   input  logic [7:0]      cfg0,
   input  logic [7:0]      cfg1,
   input  logic [7:0]      cfg2,
   input  logic            spi_3wire,
   output logic [NSIG-1:0] sig_en
);
   logic [2:0] pca_n;
   logic       unused_cfg;

   assign unused_cfg = ^{cfg2[7:6], cfg2[1]};
   assign pca_n      = (cfg0[5:3] > 3'(NCEX)) ? 3'(NCEX) : cfg0[5:3];

   always_comb begin
      sig_en                = '0;
      sig_en[S_TX0]         = cfg0[0];
      sig_en[S_RX0]         = cfg0[0];
      sig_en[S_SCK]         = cfg0[1];
      sig_en[S_MISO]        = cfg0[1];
      sig_en[S_MOSI]        = cfg0[1];
      sig_en[S_SSEL]        = cfg0[1] & ~spi_3wire;
      sig_en[S_SDA]         = cfg0[2];
      sig_en[S_SCL]         = cfg0[2];
      sig_en[S_TX1]         = cfg2[2];
      sig_en[S_RX1]         = cfg2[2];
      for (int k = 0; k < NCEX; k++)
         sig_en[int'(S_PCA0) + k] = (3'(k) < pca_n);
      sig_en[S_PCNT]        = cfg0[6];
      sig_en[S_CMP0]        = cfg0[7];
      for (int b = 0; b < 7; b++)
         sig_en[int'(S_CMP1) + b] = cfg1[b];
      sig_en[S_TMR4]        = cfg2[3];
      sig_en[S_TMR4X]       = cfg2[4];
      sig_en[S_CLKO]        = cfg1[7];
      sig_en[S_CNV0]        = cfg2[0];
      sig_en[S_CNV2]        = cfg2[5];
   end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc #(
   parameter int NPIN    = 32,
   parameter int NSIG    = 30,
   parameter int SEL_W   = 5,
   parameter int WR_PIN  = 7,
   parameter int RD_PIN  = 6,
   parameter int ALE_PIN = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NSIG-1:0]            sig_en,
   input  logic                       mem_low_en,
   input  logic                       mem_muxed,
   output logic [NPIN-1:0][SEL_W-1:0] sel_q,
   output logic                       ovf_q
);
   localparam int RK_W = (NSIG > 1) ? $clog2(NSIG) : 1;
   localparam logic [SEL_W-1:0] NONE = '1;

   if (NSIG >= (1 << SEL_W)) begin : g_bad_sel
      $error("select width too small for signal count");
   end
   if (WR_PIN >= NPIN || RD_PIN >= NPIN || ALE_PIN >= NPIN) begin : g_bad_pin
      $error("reserved pin outside bank");
   end

   logic [NPIN-1:0]            avail;
   logic [NSIG-1:0][SEL_W-1:0] by_rank;
   logic [NPIN-1:0][SEL_W-1:0] sel_d;
   logic                       ovf_d;
   int                         cnt;
   int                         r;

   always_comb begin
      avail = '1;
      if (mem_low_en) begin
         avail[WR_PIN] = 1'b0;
         avail[RD_PIN] = 1'b0;
         if (mem_muxed) avail[ALE_PIN] = 1'b0;
      end
   end

   always_comb begin
      by_rank = '1;
      cnt     = 0;
      for (int s = 0; s < NSIG; s++) begin
         if (sig_en[s]) begin
            by_rank[RK_W'(cnt)] = SEL_W'(s);
            cnt = cnt + 1;
         end
      end
      r = 0;
      for (int p = 0; p < NPIN; p++) begin
         sel_d[p] = NONE;
         if (avail[p]) begin
            if (r < cnt) sel_d[p] = by_rank[RK_W'(r)];
            r = r + 1;
         end
      end
      ovf_d = (cnt > r);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '1;
         ovf_q <= 1'b0;
      end else begin
         sel_q <= sel_d;
         ovf_q <= ovf_d;
      end
   end

   p_strobe_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mem_low_en) |-> (sel_q[WR_PIN] == NONE && sel_q[RD_PIN] == NONE));
   p_ale_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mem_low_en && mem_muxed) |-> sel_q[ALE_PIN] == NONE);
   p_overflow_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |-> sel_q[NPIN-1] != NONE);
   p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_en == '0) |=> (sel_q == '1 && !ovf_q));
endmodule

// File: rtl/xbar_pin_mux.sv
module xbar_pin_mux #(
   parameter int NPIN      = 32,
   parameter int NSIG      = 30,
   parameter int SEL_W     = 5,
   parameter bit MEM_IF_EN = 1'b1
) (
   input  logic [NPIN-1:0][SEL_W-1:0] sel_q,
   input  logic [NSIG-1:0]            sig_out,
   input  logic [NSIG-1:0]            sig_oe,
   input  logic [NPIN-1:0]            port_latch,
   input  logic [NPIN-1:0]            port_oe,
   input  logic                       mem_act,
   input  logic                       mem_rd,
   input  logic [NPIN-1:0]            mem_own,
   input  logic [NPIN-1:0]            mem_drv,
   input  logic [NPIN-1:0]            mem_data,
   output logic [NPIN-1:0]            pin_out,
   output logic [NPIN-1:0]            pin_oe
);
   localparam int NSEL = 1 << SEL_W;
   localparam logic [SEL_W-1:0] NONE = '1;

   logic [NSEL-1:0] out_ext;
   logic [NSEL-1:0] oe_ext;
   logic [NPIN-1:0] xb_out;
   logic [NPIN-1:0] xb_oe;

   always_comb begin
      out_ext = '0;
      oe_ext  = '0;
      out_ext[NSIG-1:0] = sig_out;
      oe_ext[NSIG-1:0]  = sig_oe;
   end

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      assign xb_out[p] = (sel_q[p] == NONE) ? port_latch[p] : out_ext[sel_q[p]];
      assign xb_oe[p]  = (sel_q[p] == NONE) ? port_oe[p]    : oe_ext[sel_q[p]];
   end

   if (MEM_IF_EN) begin : g_mem
      for (genvar p = 0; p < NPIN; p++) begin : g_ovr
         logic take;
         assign take       = mem_act & mem_own[p];
         assign pin_out[p] = take ? mem_drv[p] : xb_out[p];
         assign pin_oe[p]  = take ? ~(mem_rd & mem_data[p]) : xb_oe[p];
      end
   end else begin : g_nomem
      logic unused_mem;
      assign unused_mem = ^{mem_act, mem_rd, mem_own, mem_drv, mem_data};
      assign pin_out    = xb_out;
      assign pin_oe     = xb_oe;
   end
endmodule

// File: rtl/xbar_pin_crossbar.sv
module xbar_pin_crossbar
   import xbar_pkg::*;
#(
   parameter int NPIN      = 32,
   parameter int WR_PIN    = 7,
   parameter int RD_PIN    = 6,
   parameter int ALE_PIN   = 5,
   parameter bit MEM_IF_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [7:0]            cfg0,
   input  logic [7:0]            cfg1,
   input  logic [7:0]            cfg2,
   input  logic                  spi_3wire,
   input  logic                  mem_low_en,
   input  logic                  mem_muxed,
   input  logic                  mem_act,
   input  logic                  mem_rd,
   input  logic [NPIN-1:0]       mem_own,
   input  logic [NPIN-1:0]       mem_drv,
   input  logic [NPIN-1:0]       mem_data,
   input  logic [NSIG-1:0]       sig_out,
   input  logic [NSIG-1:0]       sig_oe,
   input  logic [NPIN-1:0]       port_latch,
   input  logic [NPIN-1:0]       port_oe,
   output logic [NPIN*SEL_W-1:0] pin_sel,
   output logic [NPIN-1:0]       pin_out,
   output logic [NPIN-1:0]       pin_oe,
   output logic                  overflow
);
   logic [NSIG-1:0]            sig_en;
   logic [NPIN-1:0][SEL_W-1:0] sel_q;

   xbar_enable_decode u_dec (
      .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2),
      .spi_3wire(spi_3wire), .sig_en(sig_en)
   );

   xbar_alloc #(
      .NPIN(NPIN), .NSIG(NSIG), .SEL_W(SEL_W),
      .WR_PIN(WR_PIN), .RD_PIN(RD_PIN), .ALE_PIN(ALE_PIN)
   ) u_alloc (
      .clk(clk), .rst_n(rst_n), .sig_en(sig_en),
      .mem_low_en(mem_low_en), .mem_muxed(mem_muxed),
      .sel_q(sel_q), .ovf_q(overflow)
   );

   xbar_pin_mux #(
      .NPIN(NPIN), .NSIG(NSIG), .SEL_W(SEL_W), .MEM_IF_EN(MEM_IF_EN)
   ) u_mux (
      .sel_q(sel_q), .sig_out(sig_out), .sig_oe(sig_oe),
      .port_latch(port_latch), .port_oe(port_oe),
      .mem_act(mem_act), .mem_rd(mem_rd), .mem_own(mem_own),
      .mem_drv(mem_drv), .mem_data(mem_data),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   assign pin_sel = sel_q;

   for (genvar p = 0; p < NPIN; p++) begin : g_chk
      p_no_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(spi_3wire) |-> pin_sel[p*SEL_W +: SEL_W] != S_SSEL);
      if (MEM_IF_EN) begin : g_mchk
         p_mem_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_act && mem_own[p] && !mem_rd) |-> (pin_out[p] == mem_drv[p] && pin_oe[p]));
         p_read_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_act && mem_own[p] && mem_rd && mem_data[p]) |-> !pin_oe[p]);
      end
   end
endmodule

// File: tb/tb_xbar_pin_crossbar.sv
module tb_xbar_pin_crossbar;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  cfg0, cfg1, cfg2;
   logic        spi_3wire, mem_low_en, mem_muxed, mem_act, mem_rd;
   logic [31:0] mem_own, mem_drv, mem_data, port_latch, port_oe;
   logic [29:0] sig_out, sig_oe;
   logic [159:0] pin_sel;
   logic [31:0] pin_out, pin_oe;
   logic        overflow;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   xbar_pin_crossbar dut (
      .clk(clk), .rst_n(rst_n), .cfg0(cfg0), .cfg1(cfg1), .cfg2(cfg2),
      .spi_3wire(spi_3wire), .mem_low_en(mem_low_en), .mem_muxed(mem_muxed),
      .mem_act(mem_act), .mem_rd(mem_rd), .mem_own(mem_own), .mem_drv(mem_drv),
      .mem_data(mem_data), .sig_out(sig_out), .sig_oe(sig_oe),
      .port_latch(port_latch), .port_oe(port_oe), .pin_sel(pin_sel),
      .pin_out(pin_out), .pin_oe(pin_oe), .overflow(overflow)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int sel(input int p);
      return int'(pin_sel[p*5 +: 5]);
   endfunction

   task automatic apply(input logic [7:0] c0, input logic [7:0] c1, input logic [7:0] c2,
                        input logic w3, input logic lo, input logic mx);
      @(negedge clk);
      cfg0 = c0; cfg1 = c1; cfg2 = c2;
      spi_3wire = w3; mem_low_en = lo; mem_muxed = mx;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      cfg0 = 8'hFF; cfg1 = 8'hFF; cfg2 = 8'h3D;
      spi_3wire = 0; mem_low_en = 0; mem_muxed = 0; mem_act = 0; mem_rd = 0;
      mem_own = '0; mem_drv = '0; mem_data = '0;
      sig_out = '0; sig_oe = '0; port_latch = 32'hA5; port_oe = '0;
      repeat (3) @(negedge clk);
      chk("R12 pin0 idle", sel(0), 31);
      chk("R12 pin31 idle", sel(31), 31);
      chk("R12 overflow", int'(overflow), 0);
      chk("R12 latch drive", int'(pin_out[7:0]), 8'hA5);
      @(negedge clk); rst_n = 1'b1;
      cfg0 = 0; cfg1 = 0; cfg2 = 0;
      @(negedge clk);
      chk("R12 after release", sel(0), 31);
   endtask

   task automatic t_order();
      apply(8'h03, 8'h00, 8'h00, 0, 0, 0);
      for (int p = 0; p < 6; p++) chk("R1 uart0+spi", sel(p), p);
      chk("R1 next free", sel(6), 31);
      apply(8'h80, 8'h80, 8'h24, 0, 0, 0);
      chk("R2 uart1 tx", sel(0), 8);
      chk("R2 uart1 rx", sel(1), 9);
      chk("R2 cmp0", sel(2), 17);
      chk("R2 clkout", sel(3), 27);
      chk("R2 cnv2", sel(4), 29);
      apply(8'h40, 8'h41, 8'h19, 0, 0, 0);
      chk("R2 pcnt", sel(0), 16);
      chk("R2 cmp1", sel(1), 18);
      chk("R2 tmr2x", sel(2), 24);
      chk("R2 tmr4", sel(3), 25);
      chk("R2 tmr4x", sel(4), 26);
      chk("R2 cnv0", sel(5), 28);
   endtask

   task automatic t_threewire();
      apply(8'h07, 8'h00, 8'h00, 1, 0, 0);
      chk("R5 mosi", sel(4), 4);
      chk("R5 sda moves up", sel(5), 6);
      chk("R5 scl", sel(6), 7);
      chk("R5 tail", sel(7), 31);
   endtask

   task automatic t_reserve();
      apply(8'h07, 8'h00, 8'h00, 0, 1, 0);
      chk("R3 pin5 used", sel(5), 5);
      chk("R3 pin6 free", sel(6), 31);
      chk("R3 pin7 free", sel(7), 31);
      chk("R3 sda skips", sel(8), 6);
      chk("R3 scl", sel(9), 7);
      apply(8'h07, 8'h00, 8'h00, 0, 1, 1);
      chk("R4 pin4", sel(4), 4);
      chk("R4 pin5 free", sel(5), 31);
      chk("R4 select at 8", sel(8), 5);
      chk("R4 scl at 10", sel(10), 7);
   endtask

   task automatic t_pca();
      apply(8'h19, 8'h00, 8'h00, 0, 0, 0);
      chk("R6 pca0", sel(2), 10);
      chk("R6 pca2", sel(4), 12);
      chk("R6 count 3", sel(5), 31);
      apply(8'h39, 8'h00, 8'h00, 0, 0, 0);
      chk("R6 pca5", sel(7), 15);
      chk("R6 clamp", sel(8), 31);
      apply(8'h00, 8'h00, 8'h00, 0, 0, 0);
      chk("R6 count 0", sel(0), 31);
   endtask

   task automatic t_overflow();
      apply(8'hFF, 8'hFF, 8'h3D, 0, 0, 0);
      chk("R7 all fit", sel(29), 29);
      chk("R7 spare", sel(30), 31);
      chk("R7 no flag", int'(overflow), 0);
      apply(8'hFF, 8'hFF, 8'h3D, 0, 1, 1);
      chk("R7 last pin", sel(31), 28);
      chk("R7 flag", int'(overflow), 1);
      chk("R7 pin8", sel(8), 5);
   endtask

   task automatic t_drive();
      apply(8'h01, 8'h00, 8'h00, 0, 0, 0);
      sig_out = 30'h1; sig_oe = 30'h2; port_latch = 32'h4; port_oe = 32'h8;
      #1;
      chk("R8 sig out0", int'(pin_out[0]), 1);
      chk("R8 sig oe0", int'(pin_oe[0]), 0);
      chk("R8 sig out1", int'(pin_out[1]), 0);
      chk("R8 sig oe1", int'(pin_oe[1]), 1);
      chk("R8 latch out2", int'(pin_out[2]), 1);
      chk("R8 latch oe3", int'(pin_oe[3]), 1);
      chk("R8 latch oe2", int'(pin_oe[2]), 0);
   endtask

   task automatic t_memif();
      apply(8'h00, 8'h00, 8'h00, 0, 1, 0);
      port_latch = 32'h0001_0000; port_oe = 32'h0;
      mem_own = 32'h0000_FFC0; mem_drv = 32'h0000_5580; mem_data = 32'h0000_FF00;
      mem_act = 1; mem_rd = 0;
      #1;
      chk("R9 strobe val", int'(pin_out[7]), 1);
      chk("R9 strobe oe", int'(pin_oe[7]), 1);
      chk("R9 data8", int'(pin_out[8]), 1);
      chk("R9 data9", int'(pin_out[9]), 0);
      chk("R9 data oe", int'(pin_oe[9]), 1);
      chk("R9 unowned", int'(pin_out[16]), 1);
      mem_rd = 1;
      #1;
      chk("R10 data off", int'(pin_oe[8]), 0);
      chk("R10 strobe on", int'(pin_oe[6]), 1);
      mem_act = 0;
      #1;
      chk("R9 released", int'(pin_oe[7]), 0);
      mem_rd = 0;
   endtask

   task automatic t_latency();
      apply(8'h00, 8'h00, 8'h00, 0, 0, 0);
      @(negedge clk);
      cfg1 = 8'h02;
      #1;
      chk("R11 before edge", sel(0), 31);
      @(negedge clk);
      chk("R11 after edge", sel(0), 19);
   endtask

   initial begin
      t_reset();
      t_order();
      t_threewire();
      t_reserve();
      t_pca();
      t_overflow();
      t_drive();
      t_memif();
      t_latency();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule